// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits on a byte-serial transport stream made of 188-byte packets and decides, packet by packet, whether to pass each one on. A packet begins with a byte that carries the start flag and holds the sync value 0x47. The 13-bit packet identifier is read from bytes 1 and 2 and compared in parallel against eight pattern entries. A match with any enabled entry keeps the packet. Two global controls override this: one passes every packet and the other blocks every packet.

Kept packets leave the block as 32-bit words. Each word holds four consecutive packet bytes, and a control bit selects the order of the bytes inside the word. The first word of a packet carries a start mark and the 47th word carries an end mark. A plain write/read register port holds the eight pattern words. Entry 0 also carries the global pass, block and byte-order controls.

Top module: `ts_pid_filter`

## Requirements
- R1: The pattern words sit at byte addresses 4n for n = 0..7, with the entry selected by address bits 4:2. In entries 1..7 only bit 15 (enable) and bits 12:0 (PID) are stored, and all other bits read as zero. Address bits 1:0 are ignored. An address with bit 5 set writes nothing and reads zero. The read data is combinational from the address.
- R2: Entry 0 also stores bit 16 (pass-all), bit 14 (byte order) and bit 13 (block-all). After reset every entry holds PID 0x1FFF with its enable clear, and all control bits are clear, so each word reads 0x00001FFF and nothing is forwarded.
- R3: A packet starts only on an accepted byte that has the start flag set and the value 0x47. Any other byte seen outside a packet is discarded, so a packet with a wrong first byte is dropped whole, and the block locks again on the next start-flagged 0x47.
- R4: The PID of a packet is the low 5 bits of byte 1 (the upper 3 bits are ignored) followed by all 8 bits of byte 2. The packet is forwarded when any entry, entry 0 included, has its enable set and an equal PID.
- R5: A packet is dropped when no enabled entry matches. A disabled entry holding the packet's PID does not cause forwarding.
- R6: When pass-all is set, every packet is forwarded whatever the entries and block-all hold.
- R7: When block-all is set and pass-all is clear, no packet is forwarded, even one that matches an enabled entry.
- R8: A kept packet appears as 47 words, and word k holds bytes 4k..4k+3. out_valid is high for one cycle, the cycle after the byte that completes the word. out_sop marks word 0 and out_eop marks word 46.
- R9: When byte order is 0, the earliest byte of a word is in bits 31:24. When it is 1, the earliest byte is in bits 7:0.
- R10: The keep decision and the byte order are taken from the register values present in the cycle that byte 2 is presented. A write in that cycle or later in the packet does not change how that packet is handled.
- R11: After the 188th byte, the next accepted byte must again be a start byte. A start flag raised inside a packet is ignored, and that byte is treated as payload.
- R12: Cycles with in_valid low neither advance nor disturb a packet. Bytes may arrive with gaps anywhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is a packet start |
| in_data | input | 8 | Input byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word of four packet bytes |
| out_sop | output | 1 | First word of a forwarded packet |
| out_eop | output | 1 | Last (47th) word of a forwarded packet |

## Verification
A byte counter that has slipped shows at the first forwarded word: the start and end marks land on the wrong words, or the word contents are shifted. Either shows within the four bytes after the slip. A stale or wrong keep decision shows as a whole packet of words that appear or go missing, starting one cycle after byte 3. A corrupted pattern entry shows on the read port in the cycle after the write. The reference model compares every output and the read data on every clock, so any of these is caught in the cycle it first reaches a port.

// File: rtl/ts_filt_pkg.sv
package ts_filt_pkg;

  localparam logic [7:0] SYNC_BYTE = 8'h47;
  localparam int PID_W     = 13;
  localparam int ENA_POS   = 15;
  localparam int PASS_POS  = 16;
  localparam int LSB_POS   = 14;
  localparam int BLOCK_POS = 13;
  localparam logic [PID_W-1:0] PARKED_PID = '1;

  typedef struct packed {
    logic             ena;
    logic [PID_W-1:0] pid;
  } pat_entry_t;

  typedef struct packed {
    logic pass_all;
    logic lsb_first;
    logic block_all;
  } glob_ctl_t;

endpackage

// File: rtl/ts_pattern_bank.sv
module ts_pattern_bank
  import ts_filt_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [PID_W-1:0] cand_pid,
  output logic             lsb_first,
  output logic             keep
);

  localparam int SEL_W   = $clog2(N_ENTRIES);
  localparam int SEL_LSB = 2;
  localparam int TOP_LSB = SEL_LSB + SEL_W;

  logic             in_range;
  logic [SEL_W-1:0] sel;

  assign in_range = (addr[ADDR_W-1:TOP_LSB] == '0);
  assign sel      = addr[TOP_LSB-1:SEL_LSB];

  pat_entry_t ent_q [N_ENTRIES];
  pat_entry_t ent_d [N_ENTRIES];
  glob_ctl_t  ctl_q, ctl_d;
  logic [N_ENTRIES-1:0] hit;

  // next-state for entries and controls
  always_comb begin
    for (int i = 0; i < N_ENTRIES; i++) begin
      ent_d[i] = ent_q[i];
      if (wr_en && in_range && (int'(sel) == i)) begin
        ent_d[i].ena = wdata[ENA_POS];
        ent_d[i].pid = wdata[PID_W-1:0];
      end
    end
    ctl_d = ctl_q;
    if (wr_en && in_range && (sel == '0)) begin
      ctl_d.pass_all  = wdata[PASS_POS];
      ctl_d.lsb_first = wdata[LSB_POS];
      ctl_d.block_all = wdata[BLOCK_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        ent_q[i] <= '{ena: 1'b0, pid: PARKED_PID};
      end
      ctl_q <= '0;
    end else begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        ent_q[i] <= ent_d[i];
      end
      ctl_q <= ctl_d;
    end
  end

  // parallel comparators, one per entry
  generate
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
      assign hit[g] = ent_q[g].ena && (ent_q[g].pid == cand_pid);
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (in_range) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (int'(sel) == i) begin
          rdata[ENA_POS]     = ent_q[i].ena;
          rdata[PID_W-1:0]   = ent_q[i].pid;
        end
      end
      if (sel == '0) begin
        rdata[PASS_POS]  = ctl_q.pass_all;
        rdata[LSB_POS]   = ctl_q.lsb_first;
        rdata[BLOCK_POS] = ctl_q.block_all;
      end
    end
  end

  assign lsb_first = ctl_q.lsb_first;
  assign keep      = ctl_q.pass_all | (~ctl_q.block_all & (|hit));

endmodule

// File: rtl/ts_sync_track.sv
module ts_sync_track
  import ts_filt_pkg::*;
#(
  parameter  int PKT_BYTES = 188,
  localparam int CNT_W     = $clog2(PKT_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  output logic             fire,
  output logic [CNT_W-1:0] idx
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start;

  assign start = in_valid && !busy_q && in_sop && (in_data == SYNC_BYTE);
  assign fire  = (in_valid && busy_q) || start;
  assign idx   = busy_q ? cnt_q : '0;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (fire) begin
      if (idx == CNT_W'(PKT_BYTES - 1)) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        busy_d = 1'b1;
        cnt_d  = idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/ts_word_pack.sv
module ts_word_pack
  import ts_filt_pkg::*;
#(
  parameter  int PKT_BYTES  = 188,
  parameter  int WORD_BYTES = 4,
  localparam int CNT_W      = $clog2(PKT_BYTES),
  localparam int LANE_W     = $clog2(WORD_BYTES),
  localparam int WORD_W     = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CNT_W-1:0]  idx,
  input  logic [7:0]        data,
  input  logic              dec_stb,
  input  logic              keep_in,
  input  logic              lsb_in,
  output logic [PID_W-1:0]  cand_pid,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);

  logic [7:0] hold_q [WORD_BYTES-1];
  logic [7:0] hold_d [WORD_BYTES-1];
  logic keep_q, keep_d, lsb_q, lsb_d;
  logic ov_q, ov_d, sop_q, sop_d, eop_q, eop_d;
  logic [WORD_W-1:0] od_q, od_d;
  logic [LANE_W-1:0] lane;
  logic last_lane, emit;
  logic [WORD_W-1:0] word_be, word_le;

  assign lane      = idx[LANE_W-1:0];
  assign last_lane = (lane == LANE_W'(WORD_BYTES - 1));
  assign cand_pid  = {hold_q[1][4:0], data};
  assign emit      = fire && last_lane && keep_q;

  generate
    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
      logic [7:0] lane_val;
      if (l == WORD_BYTES - 1) begin : g_live
        assign lane_val = data;
      end else begin : g_held
        assign lane_val = hold_q[l];
      end
      assign word_be[8*(WORD_BYTES-1-l) +: 8] = lane_val;
      assign word_le[8*l +: 8]                = lane_val;
    end
  endgenerate

  always_comb begin
    for (int l = 0; l < WORD_BYTES - 1; l++) begin
      hold_d[l] = hold_q[l];
      if (fire && (int'(lane) == l)) hold_d[l] = data;
    end
    keep_d = keep_q;
    lsb_d  = lsb_q;
    if (dec_stb) begin
      keep_d = keep_in;
      lsb_d  = lsb_in;
    end
    ov_d  = emit;
    od_d  = od_q;
    if (emit) od_d = lsb_q ? word_le : word_be;
    sop_d = emit && (idx == CNT_W'(WORD_BYTES - 1));
    eop_d = emit && (idx == CNT_W'(PKT_BYTES - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < WORD_BYTES - 1; l++) hold_q[l] <= '0;
      keep_q <= 1'b0;
      lsb_q  <= 1'b0;
      ov_q   <= 1'b0;
      od_q   <= '0;
      sop_q  <= 1'b0;
      eop_q  <= 1'b0;
    end else begin
      for (int l = 0; l < WORD_BYTES - 1; l++) hold_q[l] <= hold_d[l];
      keep_q <= keep_d;
      lsb_q  <= lsb_d;
      ov_q   <= ov_d;
      od_q   <= od_d;
      sop_q  <= sop_d;
      eop_q  <= eop_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_sop   = sop_q;
  assign out_eop   = eop_q;

endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter
  import ts_filt_pkg::*;
#(
  parameter  int N_ENTRIES  = 8,
  parameter  int ADDR_W     = 6,
  parameter  int PKT_BYTES  = 188,
  parameter  int WORD_BYTES = 4,
  localparam int CNT_W      = $clog2(PKT_BYTES),
  localparam int WORD_W     = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [7:0]        in_data,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);

  localparam int DECIDE_IDX = 2;

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic             fire;
  logic [CNT_W-1:0] idx;
  logic [PID_W-1:0] cand_pid;
  logic             keep, lsb_first, dec_stb;

  assign dec_stb = fire && (idx == CNT_W'(DECIDE_IDX));

  ts_sync_track #(.PKT_BYTES(PKT_BYTES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_data  (in_data),
    .fire     (fire),
    .idx      (idx)
  );

  ts_pattern_bank #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .cand_pid  (cand_pid),
    .lsb_first (lsb_first),
    .keep      (keep)
  );

  ts_word_pack #(.PKT_BYTES(PKT_BYTES), .WORD_BYTES(WORD_BYTES)) u_pack (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .fire      (fire),
    .idx       (idx),
    .data      (in_data),
    .dec_stb   (dec_stb),
    .keep_in   (keep),
    .lsb_in    (lsb_first),
    .cand_pid  (cand_pid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
  );

endmodule

// File: rtl/ts_pid_filter_chk.sv
module ts_pid_filter_chk #(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 6
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              in_valid,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              out_valid,
  input logic              out_sop,
  input logic              out_eop
);

  localparam int SEL_W   = $clog2(N_ENTRIES);
  localparam int TOP_LSB = 2 + SEL_W;

  logic armed_q;
  logic in_rng, sel_zero;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) armed_q <= 1'b0;
    else             armed_q <= 1'b1;
  end

  assign in_rng   = (reg_addr[ADDR_W-1:TOP_LSB] == '0);
  assign sel_zero = (reg_addr[TOP_LSB-1:2] == '0);

  p_readback_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (armed_q && $past(reg_wr) && ($past(reg_addr) == reg_addr) && in_rng && !sel_zero)
      |-> (reg_rdata == ($past(reg_wdata) & 32'h0000_9FFF)));

  p_ctl_readback_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (armed_q && $past(reg_wr) && ($past(reg_addr) == reg_addr) && in_rng && sel_zero)
      |-> (reg_rdata == ($past(reg_wdata) & 32'h0001_FFFF)));

  p_outside_zero_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    !in_rng |-> (reg_rdata == 32'h0));

  p_word_follows_byte_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (armed_q && out_valid) |-> $past(in_valid));

  p_word_spacing_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid |=> !out_valid);

  p_marks_need_valid_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_sop || out_eop) |-> out_valid);

  p_sop_not_eop_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_sop |-> !out_eop);

endmodule

bind ts_pid_filter ts_pid_filter_chk #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .in_valid   (in_valid),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .out_valid  (out_valid),
  .out_sop    (out_sop),
  .out_eop    (out_eop)
);

// File: tb/ts_pid_filter_bench.sv
module ts_pid_filter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sop;
  logic [7:0]  in_data;
  logic        reg_wr;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        out_valid, out_sop, out_eop;
  logic [31:0] out_data;

  always #10 clk = ~clk;

  ts_pid_filter u_ts_pid_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );

  int n_vec = 0;
  int n_bad = 0;
  int words = 0;
  int eops  = 0;
  bit done  = 0;
  logic [31:0] first_word;

  // behavioural reference model
  logic [31:0] mregs [8];
  logic [7:0]  pk [188];
  bit          m_in, m_keep, m_lsb;
  int          m_cnt;
  bit          e_v, e_sop, e_eop;
  logic [31:0] e_d;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mregs[i] = 32'h1FFF;
      m_in = 0; m_cnt = 0; m_keep = 0; m_lsb = 0;
      e_v = 0; e_sop = 0; e_eop = 0; e_d = '0;
    end else begin
      e_v = 0; e_sop = 0; e_eop = 0;
      if (in_valid) begin
        if (!m_in && in_sop && in_data == 8'h47) begin
          m_in = 1; m_cnt = 0;
        end
        if (m_in) begin
          pk[m_cnt] = in_data;
          if (m_cnt == 2) begin
            logic [12:0] pid;
            bit hit;
            pid = {pk[1][4:0], pk[2]};
            hit = 0;
            for (int e = 0; e < 8; e++)
              if (mregs[e][15] && mregs[e][12:0] == pid) hit = 1;
            m_keep = mregs[0][16] || (!mregs[0][13] && hit);
            m_lsb  = mregs[0][14];
          end
          if (m_cnt % 4 == 3 && m_keep) begin
            e_v   = 1;
            e_sop = (m_cnt == 3);
            e_eop = (m_cnt == 187);
            e_d   = m_lsb ? {pk[m_cnt], pk[m_cnt-1], pk[m_cnt-2], pk[m_cnt-3]}
                          : {pk[m_cnt-3], pk[m_cnt-2], pk[m_cnt-1], pk[m_cnt]};
          end
          m_cnt++;
          if (m_cnt == 188) begin m_in = 0; m_cnt = 0; end
        end
      end
      if (reg_wr && !reg_addr[5])
        mregs[reg_addr[4:2]] = reg_wdata & ((reg_addr[4:2] == 0) ? 32'h1FFFF : 32'h9FFF);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] exp_rd;
      n_vec++;
      if (out_valid !== e_v || (e_v && (out_data !== e_d || out_sop !== e_sop || out_eop !== e_eop))) begin
        n_bad++;
        $display("FAIL R8 output word: valid=%0b data=%h sop=%0b eop=%0b, expected valid=%0b data=%h sop=%0b eop=%0b",
                 out_valid, out_data, out_sop, out_eop, e_v, e_d, e_sop, e_eop);
      end
      exp_rd = reg_addr[5] ? 32'h0 : mregs[reg_addr[4:2]];
      n_vec++;
      if (reg_rdata !== exp_rd) begin
        n_bad++;
        $display("FAIL R1 read data at %h: %h, expected %h", reg_addr, reg_rdata, exp_rd);
      end
      if (out_valid) words++;
      if (out_valid && out_eop) eops++;
      if (out_valid && out_sop) first_word = out_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h, expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_wr = 0; reg_addr = '0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    reg_addr = a;
    #3;
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      in_valid = 0; in_sop = 0; reg_wr = 0;
    end
  endtask

  function automatic logic [7:0] pbyte(input int i, input logic [12:0] pid, input logic [7:0] sync);
    if (i == 0) return sync;
    if (i == 1) return {3'b010, pid[12:8]};
    if (i == 2) return pid[7:0];
    return 8'((i * 7 + int'(pid[7:0])) & 255);
  endfunction

  task automatic send_pkt(input logic [12:0] pid, input logic [7:0] sync, input int gap_every,
                          input bit mid_sop, input int wr_at, input logic [5:0] wa, input logic [31:0] wd);
    for (int i = 0; i < 188; i++) begin
      @(posedge clk); #2;
      in_valid = 1;
      in_sop   = (i == 0) || (mid_sop && i == 100);
      in_data  = (mid_sop && i == 100) ? 8'h47 : pbyte(i, pid, sync);
      reg_wr   = (i == wr_at);
      if (i == wr_at) begin reg_addr = wa; reg_wdata = wd; end
      else reg_addr = '0;
      if (gap_every > 0 && (i % gap_every) == gap_every - 1) begin
        @(posedge clk); #2;
        in_valid = 0; in_sop = 0; reg_wr = 0; reg_addr = '0;
      end
    end
    @(posedge clk); #2;
    in_valid = 0; in_sop = 0; reg_wr = 0; reg_addr = '0;
  endtask

  task automatic pkt_expect(input logic [12:0] pid, input logic [7:0] sync, input int gap_every,
                            input bit mid_sop, input int wr_at, input logic [5:0] wa, input logic [31:0] wd,
                            input int exp_words, input string tag);
    int w0, e0;
    w0 = words; e0 = eops;
    send_pkt(pid, sync, gap_every, mid_sop, wr_at, wa, wd);
    idle(4);
    chk(words - w0 == exp_words, tag, words - w0, exp_words);
    chk(eops - e0 == (exp_words == 47 ? 1 : 0), {tag, " end marks"}, eops - e0, (exp_words == 47) ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_sop = 0; in_data = '0;
    reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk); #2;
    rst_n = 1;
    repeat (4) @(posedge clk);

    // R2 reset state
    rd_chk(6'h00, 32'h1FFF, "R2 reset entry 0");
    rd_chk(6'h1C, 32'h1FFF, "R2 reset entry 7");
    chk(out_valid === 1'b0, "R2 reset output idle", 32'(out_valid), 0);

    // R1 storage mask and out-of-range addressing
    wr(6'h04, 32'hFFFF_FFFF);
    rd_chk(6'h04, 32'h0000_9FFF, "R1 entry 1 stored bits");
    wr(6'h24, 32'h0000_8123);
    rd_chk(6'h24, 32'h0, "R1 out-of-range reads zero");
    rd_chk(6'h04, 32'h0000_9FFF, "R1 out-of-range write ignored");
    rd_chk(6'h07, 32'h0000_9FFF, "R1 low address bits ignored");
    wr(6'h04, 32'h0000_1FFF);

    // R4 match on entry 3, R8 framing, R9 big-endian order
    wr(6'h0C, 32'h0000_8100);
    pkt_expect(13'h100, 8'h47, 0, 0, -1, 0, 0, 47, "R4 enabled match forwarded");
    chk(first_word[31:24] == 8'h47, "R9 earliest byte high when order bit clear", first_word, 32'h47xxxxxx);
    pkt_expect(13'h101, 8'h47, 0, 0, -1, 0, 0, 0, "R5 unmatched dropped");

    // R5 disabled entry
    wr(6'h14, 32'h0000_0200);
    pkt_expect(13'h200, 8'h47, 0, 0, -1, 0, 0, 0, "R5 disabled entry ignored");

    // R4 entry 0 as a match entry
    wr(6'h00, 32'h0000_8055);
    pkt_expect(13'h055, 8'h47, 0, 0, -1, 0, 0, 47, "R4 entry 0 match");

    // R7 block-all
    wr(6'h00, 32'h0000_A055);
    pkt_expect(13'h100, 8'h47, 0, 0, -1, 0, 0, 0, "R7 block-all drops match");

    // R6 pass-all overrides block-all
    wr(6'h00, 32'h0001_2000);
    pkt_expect(13'h777, 8'h47, 0, 0, -1, 0, 0, 47, "R6 pass-all forwards");

    // R9 little-endian order
    wr(6'h00, 32'h0000_4000);
    pkt_expect(13'h100, 8'h47, 0, 0, -1, 0, 0, 47, "R9 order bit set forwarded");
    chk(first_word[7:0] == 8'h47, "R9 earliest byte low when order bit set", first_word, 32'hxxxxxx47);
    wr(6'h00, 32'h0000_0000);

    // R3 bad sync then resync
    pkt_expect(13'h100, 8'h46, 0, 0, -1, 0, 0, 0, "R3 bad sync packet dropped");
    pkt_expect(13'h100, 8'h47, 0, 0, -1, 0, 0, 47, "R3 resync on next start");

    // R12 bubbles
    pkt_expect(13'h100, 8'h47, 5, 0, -1, 0, 0, 47, "R12 gaps in stream");

    // R11 start flag inside a packet ignored
    pkt_expect(13'h100, 8'h47, 0, 1, -1, 0, 0, 47, "R11 inner start flag ignored");
    pkt_expect(13'h100, 8'h47, 0, 0, -1, 0, 0, 47, "R11 next packet aligned");

    // R10 decision held after byte 2
    pkt_expect(13'h100, 8'h47, 0, 0, 60, 6'h0C, 32'h0000_0100, 47, "R10 late disable keeps packet");
    pkt_expect(13'h100, 8'h47, 0, 0, -1, 0, 0, 0, "R10 disable applies next packet");
    pkt_expect(13'h333, 8'h47, 0, 0, 2, 6'h00, 32'h0001_0000, 0, "R10 write at byte 2 too late");
    pkt_expect(13'h333, 8'h47, 0, 0, -1, 0, 0, 47, "R10 write applies next packet");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule